// File: doc/BRIEF.md
# Segmented match-line ternary CAM

This block is a 32-entry, 64-bit ternary content addressable memory. Every entry holds a data value and a care vector. A care bit of 1 makes the stored bit take part in the comparison. A care bit of 0 makes that bit match either key value. Entries are loaded through a write port, and an erase port removes them. A search reports whether any live entry matches a key, and the lowest-numbered matching entry.

The comparison of each entry is split into eight cascaded 8-bit slices, evaluated one slice per clock. An entry drops out of the search at its first slice that mismatches, so its later slices are never compared. A slice whose eight care bits are all zero is flagged as blank when the entry is written. A blank slice is skipped and costs nothing. A running counter totals the slice comparisons actually carried out, and serves as a proxy for search energy.

Top module: `tcam_segmented`

## Requirements
- R1: A stored bit whose care bit is 1 matches only a key bit of equal value. A stored bit whose care bit is 0 matches either key value.
- R2: On completion, `srch_hit` is 1 exactly when at least one valid entry matches the key in all care bits. `srch_addr` is then the lowest such index. When nothing matches, `srch_hit` is 0 and `srch_addr` is 0.
- R3: An erase clears the entry's valid flag, and an erased entry never hits, whatever data it holds. A write and an erase to the same address in the same cycle leave the entry invalid.
- R4: A search accepted at a clock edge raises `srch_done` for exactly one cycle, 8 edges later. `srch_hit` and `srch_addr` change only in the cycle where `srch_done` is high, and hold their values otherwise.
- R5: A `srch_start` that arrives while a search is in progress is ignored. It does not alter the running search's result, its timing or the counter.
- R6: A slice whose eight care bits are all 0 is blank. A blank slice is not compared and adds nothing to `seg_count`. An entry whose slices are all blank matches any key at zero cost.
- R7: Slice k of an entry is compared only if every earlier non-blank slice of that entry matched. Each comparison carried out, whether it matches or not, adds one to `seg_count`. The counter changes only while a search runs.
- R8: After reset, `srch_done`, `srch_hit`, `srch_addr` and `seg_count` are 0 and no entry is valid.
- R9: A write replaces the data and care vector of the addressed entry and marks it valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Entry to write |
| wr_data | input | 64 | Data value to store |
| wr_care | input | 64 | Care vector (1 = bit compared) |
| er_en | input | 1 | Erase strobe |
| er_addr | input | 5 | Entry to erase |
| srch_start | input | 1 | Begin a search (ignored while busy) |
| srch_key | input | 64 | Search key, captured at start |
| srch_done | output | 1 | One-cycle completion pulse |
| srch_hit | output | 1 | Some valid entry matched |
| srch_addr | output | 5 | Lowest matching entry index |
| seg_count | output | 32 | Total slice comparisons performed |

## Verification
A write or erase takes effect at the edge where it is sampled. A search result and the `srch_done` pulse appear 8 edges after the edge that accepts `srch_start`. The counter climbs by each stage's comparison count on each of those 8 edges, one stage per edge. The bench's behavioural model advances by the same edges. It keeps per-stage comparison totals and the pending result, and all four outputs are compared with the model at every falling edge, so a result that comes one cycle early or late fails. Searches are never overlapped with writes to the array, so the model can evaluate each search entirely at its start edge.

// File: rtl/tcam_pkg.sv
// Shared types for the segmented ternary CAM.
package tcam_pkg;
    // Search sequencer states.
    typedef enum logic {
        S_IDLE = 1'b0,
        S_RUN  = 1'b1
    } srch_state_t;
endpackage

// File: rtl/tcam_word_store.sv
// Entry storage: data, care vector, per-slice blank flags and valid flags.
// Assumes write and erase may both fire in one cycle; erase then wins.
// Data, care and blank flags are not reset: valid gates their use.
module tcam_word_store #(
    parameter int WORDS = 32,
    parameter int WIDTH = 64,
    parameter int SEG_W = 8,
    parameter int NSEG  = WIDTH / SEG_W,
    parameter int AW    = $clog2(WORDS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [AW-1:0]                    wr_addr,
    input  logic [WIDTH-1:0]                 wr_data,
    input  logic [WIDTH-1:0]                 wr_care,
    input  logic                             er_en,
    input  logic [AW-1:0]                    er_addr,
    output logic [WORDS-1:0][WIDTH-1:0]      val_q,
    output logic [WORDS-1:0][WIDTH-1:0]      care_q,
    output logic [WORDS-1:0][NSEG-1:0]       blank_q,
    output logic [WORDS-1:0]                 valid_q
);
    logic [NSEG-1:0] wr_blank;

    // One blank detector per slice of the incoming care vector.
    for (genvar s = 0; s < NSEG; s++) begin : g_blank
        assign wr_blank[s] = ~|wr_care[s*SEG_W +: SEG_W];
    end

    // Store data, care vector and blank flags on a write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            val_q[wr_addr]   <= wr_data;
            care_q[wr_addr]  <= wr_care;
            blank_q[wr_addr] <= wr_blank;
        end
    end

    // Maintain valid flags; an erase overrides a same-cycle write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (wr_en) valid_q[wr_addr] <= 1'b1;
            if (er_en) valid_q[er_addr] <= 1'b0;
        end
    end
endmodule

// File: rtl/tcam_seg_compare.sv
// Compares one selected slice of every entry against the same key slice.
// seg_ok: slice is blank or matches in all care bits.
// seg_eval: slice is not blank, so comparing it costs one unit.
module tcam_seg_compare #(
    parameter int WORDS = 32,
    parameter int WIDTH = 64,
    parameter int SEG_W = 8,
    parameter int NSEG  = WIDTH / SEG_W,
    parameter int SW    = (NSEG > 1) ? $clog2(NSEG) : 1
) (
    input  logic [SW-1:0]                    stage,
    input  logic [WIDTH-1:0]                 key,
    input  logic [WORDS-1:0][WIDTH-1:0]      val,
    input  logic [WORDS-1:0][WIDTH-1:0]      care,
    input  logic [WORDS-1:0][NSEG-1:0]       blank,
    output logic [WORDS-1:0]                 seg_ok,
    output logic [WORDS-1:0]                 seg_eval
);
    logic [SEG_W-1:0] key_seg;

    // Select the key slice for the current stage.
    assign key_seg = key[stage*SEG_W +: SEG_W];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [SEG_W-1:0] diff;
        // Masked difference of this entry's slice against the key slice.
        always_comb begin
            diff        = (key_seg ^ val[w][stage*SEG_W +: SEG_W])
                        & care[w][stage*SEG_W +: SEG_W];
            seg_eval[w] = ~blank[w][stage];
            seg_ok[w]   = blank[w][stage] | ~|diff;
        end
    end
endmodule

// File: rtl/tcam_prio_enc.sv
// Lowest-index priority encoder; idx is 0 when no request is set.
module tcam_prio_enc #(
    parameter int WORDS = 32,
    parameter int AW    = $clog2(WORDS)
) (
    input  logic [WORDS-1:0] req,
    output logic             any,
    output logic [AW-1:0]    idx
);
    // Scan downward so the lowest set index is kept last.
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = WORDS - 1; i >= 0; i--) begin
            if (req[i]) idx = AW'(i);
        end
    end
endmodule

// File: rtl/tcam_segmented.sv
// Segmented match-line ternary CAM top.
// A search captures the key and the valid set, then walks one slice per
// clock. Entries leave the live set at their first mismatching slice.
// Blank slices are passed without cost. After the last slice, the result
// and a done pulse are registered. The array must not be written during
// a search.
module tcam_segmented #(
    parameter int WORDS = 32,
    parameter int WIDTH = 64,
    parameter int SEG_W = 8,
    parameter int CNT_W = 32,
    localparam int NSEG = WIDTH / SEG_W,
    localparam int AW   = $clog2(WORDS),
    localparam int SW   = (NSEG > 1) ? $clog2(NSEG) : 1,
    localparam int CW   = $clog2(WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [WIDTH-1:0] wr_care,
    input  logic             er_en,
    input  logic [AW-1:0]    er_addr,
    input  logic             srch_start,
    input  logic [WIDTH-1:0] srch_key,
    output logic             srch_done,
    output logic             srch_hit,
    output logic [AW-1:0]    srch_addr,
    output logic [CNT_W-1:0] seg_count
);
    import tcam_pkg::*;

    logic [WORDS-1:0][WIDTH-1:0] val_q;
    logic [WORDS-1:0][WIDTH-1:0] care_q;
    logic [WORDS-1:0][NSEG-1:0]  blank_q;
    logic [WORDS-1:0]            valid_q;

    srch_state_t      state;
    logic [SW-1:0]    stage;
    logic [WIDTH-1:0] key_q;
    logic [WORDS-1:0] alive;
    logic [WORDS-1:0] seg_ok;
    logic [WORDS-1:0] seg_eval;
    logic [WORDS-1:0] alive_nxt;
    logic [WORDS-1:0] cost_vec;
    logic [CW-1:0]    stage_cost;
    logic             any_hit;
    logic [AW-1:0]    first_idx;
    logic             busy;
    logic             last_stage;

    tcam_word_store #(
        .WORDS(WORDS), .WIDTH(WIDTH), .SEG_W(SEG_W), .NSEG(NSEG), .AW(AW)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_care(wr_care),
        .er_en(er_en), .er_addr(er_addr),
        .val_q(val_q), .care_q(care_q), .blank_q(blank_q), .valid_q(valid_q)
    );

    tcam_seg_compare #(
        .WORDS(WORDS), .WIDTH(WIDTH), .SEG_W(SEG_W), .NSEG(NSEG), .SW(SW)
    ) u_cmp (
        .stage(stage), .key(key_q),
        .val(val_q), .care(care_q), .blank(blank_q),
        .seg_ok(seg_ok), .seg_eval(seg_eval)
    );

    tcam_prio_enc #(
        .WORDS(WORDS), .AW(AW)
    ) u_enc (
        .req(alive_nxt), .any(any_hit), .idx(first_idx)
    );

    assign busy       = (state == S_RUN);
    assign last_stage = (stage == SW'(NSEG - 1));
    assign alive_nxt  = alive & seg_ok;
    assign cost_vec   = alive & seg_eval;

    // Count the entries whose current slice is actually compared.
    always_comb begin
        stage_cost = '0;
        for (int i = 0; i < WORDS; i++) begin
            stage_cost = stage_cost + CW'(cost_vec[i]);
        end
    end

    // Search sequencer: capture, walk the slices, register the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            stage     <= '0;
            key_q     <= '0;
            alive     <= '0;
            srch_done <= 1'b0;
            srch_hit  <= 1'b0;
            srch_addr <= '0;
        end else begin
            srch_done <= 1'b0;
            if (!busy) begin
                if (srch_start) begin
                    key_q <= srch_key;
                    alive <= valid_q;
                    stage <= '0;
                    state <= S_RUN;
                end
            end else begin
                alive <= alive_nxt;
                if (last_stage) begin
                    state     <= S_IDLE;
                    srch_done <= 1'b1;
                    srch_hit  <= any_hit;
                    srch_addr <= first_idx;
                end else begin
                    stage <= stage + 1'b1;
                end
            end
        end
    end

    // Activity counter: add this stage's comparisons while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_count <= '0;
        end else if (busy) begin
            seg_count <= seg_count + CNT_W'(stage_cost);
        end
    end
endmodule

// File: rtl/tcam_segmented_chk.sv
// Temporal checks for tcam_segmented, attached by bind below.
// Assumes the synchronous active-low reset of the top module.
module tcam_segmented_chk #(
    parameter int WORDS = 32,
    parameter int NSEG  = 8,
    parameter int AW    = 5,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             srch_start,
    input logic             busy,
    input logic             srch_done,
    input logic             srch_hit,
    input logic [AW-1:0]    srch_addr,
    input logic [CNT_W-1:0] seg_count
);
    logic        past_ok;
    logic [15:0] lat;

    // Mark that at least one edge has passed since reset released.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // Edges elapsed since the most recently accepted search.
    always_ff @(posedge clk) begin
        if (!rst_n)                  lat <= '0;
        else if (srch_start && !busy) lat <= '0;
        else if (busy)                lat <= lat + 16'd1;
    end

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        srch_done |=> !srch_done);

    assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        srch_done |-> (lat == 16'(NSEG)));

    assert_result_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !srch_done) |-> ($stable(srch_hit) && $stable(srch_addr)));

    assert_miss_addr_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_done && !srch_hit) |-> (srch_addr == '0));

    assert_count_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(busy)) |-> $stable(seg_count));

    assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((seg_count - $past(seg_count)) <= CNT_W'(WORDS)));
endmodule

bind tcam_segmented tcam_segmented_chk #(
    .WORDS(WORDS), .NSEG(NSEG), .AW(AW), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .srch_start(srch_start), .busy(busy),
    .srch_done(srch_done), .srch_hit(srch_hit), .srch_addr(srch_addr),
    .seg_count(seg_count)
);

// File: tb/tcam_segmented_test.sv
// Bench for tcam_segmented: behavioural model compared at every falling edge.
module tcam_segmented_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [63:0] wr_care = '0;
    logic        er_en = 1'b0;
    logic [4:0]  er_addr = '0;
    logic        srch_start = 1'b0;
    logic [63:0] srch_key = '0;
    logic        srch_done;
    logic        srch_hit;
    logic [4:0]  srch_addr;
    logic [31:0] seg_count;

    int checks = 0;
    int errors = 0;
    string cur_req = "R8";
    bit started = 0;
    int cycles = 0;

    // Model state.
    logic [63:0] m_val [32];
    logic [63:0] m_care [32];
    bit          m_valid [32];
    bit          m_busy = 0;
    int          m_stage = 0;
    int          m_delta [8];
    bit          p_hit = 0;
    int          p_addr = 0;
    bit          exp_done = 0;
    bit          exp_hit = 0;
    int          exp_addr = 0;
    longint      exp_count = 0;

    tcam_segmented uut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_care(wr_care),
        .er_en(er_en), .er_addr(er_addr),
        .srch_start(srch_start), .srch_key(srch_key),
        .srch_done(srch_done), .srch_hit(srch_hit), .srch_addr(srch_addr),
        .seg_count(seg_count)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        bit was_busy;
        started = 1;
        if (!rst_n) begin
            foreach (m_valid[i]) m_valid[i] = 0;
            m_busy = 0; m_stage = 0;
            exp_done = 0; exp_hit = 0; exp_addr = 0; exp_count = 0;
        end else begin
            was_busy = m_busy;
            exp_done = 0;
            if (was_busy) begin
                exp_count += m_delta[m_stage];
                if (m_stage == 7) begin
                    m_busy = 0; exp_done = 1;
                    exp_hit = p_hit; exp_addr = p_addr;
                end else m_stage++;
            end
            if (!was_busy && srch_start) begin
                foreach (m_delta[s]) m_delta[s] = 0;
                p_hit = 0; p_addr = 0;
                for (int w = 31; w >= 0; w--) begin
                    if (m_valid[w]) begin
                        for (int s = 0; s < 8; s++) begin
                            logic [7:0] c, d;
                            c = m_care[w][s*8 +: 8];
                            d = (m_val[w][s*8 +: 8] ^ srch_key[s*8 +: 8]) & c;
                            if (c != 0) begin
                                m_delta[s]++;
                                if (d != 0) break;
                            end
                        end
                        if (((m_val[w] ^ srch_key) & m_care[w]) == 0) begin
                            p_hit = 1; p_addr = w;
                        end
                    end
                end
                m_busy = 1; m_stage = 0;
            end
            if (wr_en) begin
                m_val[wr_addr] = wr_data; m_care[wr_addr] = wr_care;
                m_valid[wr_addr] = 1;
            end
            if (er_en) m_valid[er_addr] = 0;
        end
    end

    // Compare every output with the model away from the rising edge.
    always @(negedge clk) begin
        if (started) begin
            chk(srch_done == exp_done, "srch_done", srch_done, exp_done);
            chk(seg_count == exp_count[31:0], "seg_count", seg_count, exp_count);
            chk(srch_hit == exp_hit, "srch_hit", srch_hit, exp_hit);
            chk(srch_addr == 5'(exp_addr), "srch_addr", srch_addr, exp_addr);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic write_word(input int a, input logic [63:0] d, input logic [63:0] c);
        @(negedge clk);
        wr_en = 1; wr_addr = 5'(a); wr_data = d; wr_care = c;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic erase_word(input int a);
        @(negedge clk);
        er_en = 1; er_addr = 5'(a);
        @(negedge clk);
        er_en = 0;
    endtask

    task automatic search(input logic [63:0] k);
        @(negedge clk);
        srch_start = 1; srch_key = k;
        @(negedge clk);
        srch_start = 0;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        logic [63:0] base, care;
        repeat (3) @(negedge clk);
        // R8: reset state is checked by the per-edge comparison.
        cur_req = "R8";
        chk(srch_done == 0 && srch_hit == 0 && seg_count == 0, "reset outputs",
            {srch_done, srch_hit, seg_count}, 0);
        rst_n = 1;
        @(negedge clk);
        search(64'h0);

        // R9/R2: exact match with every bit cared.
        cur_req = "R9";
        base = 64'h0123_4567_89AB_CDEF;
        write_word(5, base, '1);
        search(base);
        // R7: mismatch in slice 0 stops after one comparison.
        cur_req = "R7";
        search(base ^ 64'h1);
        // R7: mismatch in slice 5 costs six comparisons.
        search(base ^ (64'h1 << 44));

        // R1: ternary bits accept either key value.
        cur_req = "R1";
        write_word(9, 64'hFFFF_0000_FFFF_0000, 64'h0F0F_0F0F_0F0F_0F0F);
        search(64'h3F5F_0000_FFFF_A0B0);
        search(64'h0000_0000_0000_0000);
        search(64'h0F0F_0000_0F0F_0000);

        // R2: lowest index among several matches.
        cur_req = "R2";
        write_word(3, 64'hDEAD_BEEF_0000_1111, '1);
        write_word(7, 64'hDEAD_BEEF_0000_1111, '1);
        search(64'hDEAD_BEEF_0000_1111);

        // R3: erase removes an entry; erase wins over same-cycle write.
        cur_req = "R3";
        erase_word(3);
        search(64'hDEAD_BEEF_0000_1111);
        @(negedge clk);
        wr_en = 1; wr_addr = 5'd7; wr_data = 64'hDEAD_BEEF_0000_1111; wr_care = '1;
        er_en = 1; er_addr = 5'd7;
        @(negedge clk);
        wr_en = 0; er_en = 0;
        search(64'hDEAD_BEEF_0000_1111);

        // R6: fully blank entry matches anything at no cost; partly blank slices skipped.
        cur_req = "R6";
        write_word(20, 64'h1234, '0);
        search(64'hAAAA_5555_AAAA_5555);
        write_word(21, 64'hFF00_0000_0000_00FF, 64'hFF00_0000_0000_00FF);
        search(64'hFF12_3456_789A_BCFF);

        // R5: a second start during a running search is ignored.
        cur_req = "R5";
        @(negedge clk);
        srch_start = 1; srch_key = base;
        @(negedge clk);
        srch_start = 0;
        repeat (3) @(negedge clk);
        srch_start = 1; srch_key = 64'h0;
        @(negedge clk);
        srch_start = 0;
        repeat (10) @(negedge clk);

        // R4/R2: random entries and keys; result timing and holding compared each cycle.
        cur_req = "R4";
        for (int it = 0; it < 60; it++) begin
            base = {$urandom, $urandom};
            care = {$urandom, $urandom} & {$urandom, $urandom};
            write_word(int'($urandom % 32), base, care);
            if (it % 7 == 3) erase_word(int'($urandom % 32));
            if (it % 2 == 0) search(base ^ ({$urandom, $urandom} & ~care));
            else             search({$urandom, $urandom});
        end

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule